// File: doc/BRIEF.md
# Up/Down Auto-Reload Timer/Counter

This block is an 8-bit counter that advances on a chosen count strobe, either upward or downward. The strobe comes from one of several internal tick inputs or from edges on an external event pin. The tick inputs come from a prescaler outside the block. In free-running (interval) mode the counter wraps from 0xFF to 0x00, or from 0x00 to 0xFF. In auto-reload mode every wrap instead loads the count from a reload register. This gives a programmable period of 1 to 256 strobes. Each wrap produces a one-cycle pulse and sets a sticky flag that drives an interrupt line.

Software reaches the block through a plain register port. A write is taken on any clock edge where `bus_wr` is high. A read is combinational from `bus_addr`. The port has no handshake and no back-pressure, so every write is accepted in its cycle. The port carries no data stream, so no valid/ready interface is used. The direction pin and the tick strobes must be synchronous to `clk`. The event pin may be asynchronous.

Top module: `updn_reload_timer`

## Requirements
- R1: After reset, the control, reload, count and status registers all read 0, and `irq_o` and `wrap_o` are low.
- R2: In interval mode, counting up, each selected strobe adds 1 to the count. A strobe at 0xFF gives 0x00. The wrap raises `wrap_o` for exactly the following cycle and sets the flag.
- R3: In interval mode, counting down, each selected strobe subtracts 1 from the count. A strobe at 0x00 gives 0xFF and is signalled as a wrap.
- R4: With control bit 7 = 1 (auto-reload), a wrap loads the count from the reload register. The period is 256−R strobes counting up and R+1 strobes counting down, so it always lies between 1 and 256.
- R5: A write to the reload register (address 1) in auto-reload mode also writes the same value into the count at once. In interval mode the same write leaves the count unchanged.
- R6: Control bits 2..0 select the strobe source. Values 0 to 6 select `tick_i[value]`, and all other tick inputs are ignored.
- R7: Select value 7 counts edges of `event_pin`. Control bit 4 = 0 counts rising edges and 1 counts falling edges. The event pin passes through a two-flop synchronizer, so the count changes on the third rising clock edge after the pin change. In this mode the tick inputs are ignored.
- R8: With control bit 6 = 0, control bit 5 sets the direction (1 = down, 0 = up). With bit 6 = 1, `dir_pin` sets it (high = down) and bit 5 is ignored.
- R9: The flag (status bit 0) stays set until software writes a 0 to status bit 0. Writing a 1 to that bit has no effect. A wrap in the same cycle as a clear leaves the flag set. `irq_o` equals the flag.
- R10: The count moves by at most one step per clock, even when several tick inputs are high together. A register write that loads the count (a count write, or a reload write in auto-reload mode) takes priority over a strobe in the same cycle.
- R11: Register map: address 0 is control, 1 is reload, 2 is count (writable), and 3 is status. Control bit 3 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Combinational read data |
| tick_i | input | NTICK | Internal count strobes, one cycle each |
| event_pin | input | 1 | External event input (asynchronous) |
| dir_pin | input | 1 | External direction input, high = down |
| wrap_o | output | 1 | One-cycle pulse after each overflow/underflow |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
The count is readable combinationally at every cycle. A wrong step, a wrong wrap value or a missed reload therefore appears on the very next read of address 2, in the cycle after the offending edge. A synchronizer or edge detector holding the wrong state shifts the external count by a cycle or adds or drops a step, which is visible when the count is sampled exactly at the third clock edge after a pin change. A flag that is set or cleared wrongly appears on `irq_o` in the cycle after the wrap or the clear write.

// File: rtl/updn_timer_pkg.sv
package updn_timer_pkg;

  localparam int unsigned SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_EXT = 3'b111;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_RELOAD = 2'd1,
    REG_COUNT  = 2'd2,
    REG_STATUS = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic             reload_mode;
    logic             hw_dir;
    logic             sw_down;
    logic             fall_edge;
    logic [SEL_W-1:0] clk_sel;
  } ctrl_t;

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic fall_i,
  output logic pulse_o
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              level;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], pin_i};
      end
    end
  endgenerate

  assign level = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= level;
  end

  assign pulse_o = fall_i ? (last_q & ~level) : (level & ~last_q);

  // R7: one pin transition yields a single strobe
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);

endmodule

// File: rtl/tmr_step_select.sv
module tmr_step_select
  import updn_timer_pkg::*;
#(
  parameter int unsigned NTICK = 7
) (
  input  logic [NTICK-1:0] tick_i,
  input  logic             ext_pulse_i,
  input  logic [SEL_W-1:0] clk_sel_i,
  input  logic             hw_dir_i,
  input  logic             sw_down_i,
  input  logic             dir_pin_i,
  output logic             step_o,
  output logic             down_o
);

  logic tick_hit;

  always_comb begin
    tick_hit = 1'b0;
    for (int i = 0; i < NTICK; i++) begin
      if (clk_sel_i == SEL_W'(i)) tick_hit = tick_i[i];
    end
  end

  assign step_o = (clk_sel_i == SEL_EXT) ? ext_pulse_i : tick_hit;
  assign down_o = hw_dir_i ? dir_pin_i : sw_down_i;

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             down_i,
  input  logic             reload_mode_i,
  input  logic [WIDTH-1:0] reload_val_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  output logic [WIDTH-1:0] count_o,
  output logic             wrap_evt_o,
  output logic             wrap_o
);

  localparam logic [WIDTH-1:0] MAXV = '1;
  localparam logic [WIDTH-1:0] MINV = '0;

  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic             wrap_evt, wrap_q;

  always_comb begin
    cnt_d    = cnt_q;
    wrap_evt = 1'b0;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (step_i) begin
      if (!down_i) begin
        if (cnt_q == MAXV) begin
          wrap_evt = 1'b1;
          cnt_d    = reload_mode_i ? reload_val_i : MINV;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == MINV) begin
          wrap_evt = 1'b1;
          cnt_d    = reload_mode_i ? reload_val_i : MAXV;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wrap_q <= wrap_evt;
    end
  end

  assign count_o    = cnt_q;
  assign wrap_evt_o = wrap_evt;
  assign wrap_o     = wrap_q;

  // R2
  a_r2_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && !down_i && cnt_q != MAXV) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R3
  a_r3_down_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && down_i && cnt_q != MINV) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R4
  a_r4_reload_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && reload_mode_i &&
     ((!down_i && cnt_q == MAXV) || (down_i && cnt_q == MINV)))
    |=> (cnt_q == $past(reload_val_i)));
  // R2
  a_r2_wrap_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |-> $past(step_i && !load_i));
  // R10
  a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> $stable(cnt_q));
  // R10: a load beats a step in the same cycle
  a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i)));

endmodule

// File: rtl/updn_reload_timer.sv
module updn_reload_timer
  import updn_timer_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned NTICK       = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [NTICK-1:0] tick_i,
  input  logic             event_pin,
  input  logic             dir_pin,
  output logic             wrap_o,
  output logic             irq_o
);

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  ctrl_t            ctrl_q;
  logic [WIDTH-1:0] reload_q;
  logic             flag_q;
  logic [WIDTH-1:0] count;
  logic             ext_pulse, step, down, wrap_evt;
  logic             wr_ctrl, wr_reload, wr_count, wr_status;
  logic             load, flag_clr;
  logic [7:0]       ctrl_view;

  assign wr_ctrl   = bus_wr && (bus_addr == REG_CTRL);
  assign wr_reload = bus_wr && (bus_addr == REG_RELOAD);
  assign wr_count  = bus_wr && (bus_addr == REG_COUNT);
  assign wr_status = bus_wr && (bus_addr == REG_STATUS);

  assign load     = wr_count || (wr_reload && ctrl_q.reload_mode);
  assign flag_clr = wr_status && !bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      flag_q   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.reload_mode <= bus_wdata[7];
        ctrl_q.hw_dir      <= bus_wdata[6];
        ctrl_q.sw_down     <= bus_wdata[5];
        ctrl_q.fall_edge   <= bus_wdata[4];
        ctrl_q.clk_sel     <= bus_wdata[SEL_W-1:0];
      end
      if (wr_reload) reload_q <= bus_wdata;
      flag_q <= wrap_evt | (flag_q & ~flag_clr);
    end
  end

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_i   (event_pin),
    .fall_i  (ctrl_q.fall_edge),
    .pulse_o (ext_pulse)
  );

  tmr_step_select #(.NTICK(NTICK)) u_sel (
    .tick_i      (tick_i),
    .ext_pulse_i (ext_pulse),
    .clk_sel_i   (ctrl_q.clk_sel),
    .hw_dir_i    (ctrl_q.hw_dir),
    .sw_down_i   (ctrl_q.sw_down),
    .dir_pin_i   (dir_pin),
    .step_o      (step),
    .down_o      (down)
  );

  tmr_count_core #(.WIDTH(WIDTH)) u_core (
    .clk           (clk),
    .rst_n         (rst_n),
    .step_i        (step),
    .down_i        (down),
    .reload_mode_i (ctrl_q.reload_mode),
    .reload_val_i  (reload_q),
    .load_i        (load),
    .load_val_i    (bus_wdata),
    .count_o       (count),
    .wrap_evt_o    (wrap_evt),
    .wrap_o        (wrap_o)
  );

  // control byte as seen by software; bit 3 has no storage
  assign ctrl_view = {ctrl_q.reload_mode, ctrl_q.hw_dir, ctrl_q.sw_down,
                      ctrl_q.fall_edge, 1'b0, ctrl_q.clk_sel};

  always_comb begin
    case (reg_addr_e'(bus_addr))
      REG_CTRL:   bus_rdata = WIDTH'(ctrl_view);
      REG_RELOAD: bus_rdata = reload_q;
      REG_COUNT:  bus_rdata = count;
      REG_STATUS: bus_rdata = WIDTH'(flag_q);
      default:    bus_rdata = '0;
    endcase
  end

  assign irq_o = flag_q;

  // R9: flag stays set until an explicit clear
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !flag_clr) |=> irq_o);
  // R9: every wrap leaves the flag set
  a_r9_flag_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |-> irq_o);
  // R11: the control view is narrower than the bus only by design
  a_r11_ctrl_width: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (ctrl_q.clk_sel == $past(bus_wdata[SEL_W-1:0])));

  initial begin
    assert (CTRL_W == 7 && WIDTH >= 8 && NTICK <= 7 && SYNC_STAGES >= 1)
      else $error("updn_reload_timer: unsupported parameters");
  end

endmodule

// File: tb/sim_updn_reload_timer.sv
module sim_updn_reload_timer;
  localparam int W  = 8;
  localparam int NT = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [1:0]    bus_addr = 2'd0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic [NT-1:0] tick_i = '0;
  logic          event_pin = 1'b0;
  logic          dir_pin = 1'b0;
  logic          wrap_o, irq_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  updn_reload_timer #(.WIDTH(W), .NTICK(NT), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_i(tick_i),
    .event_pin(event_pin), .dir_pin(dir_pin), .wrap_o(wrap_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic ticks(input int idx, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i[idx] = 1'b1;
      @(negedge clk); tick_i[idx] = 1'b0;
    end
  endtask

  task automatic t_reset;
    logic [7:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v); chk("R1 reg after reset", v, 8'h00);
    end
    chk("R1 irq after reset", irq_o, 1'b0);
    chk("R1 wrap after reset", wrap_o, 1'b0);
  endtask

  task automatic t_interval_up;
    logic [7:0] v;
    wr(2'd0, 8'h00);
    wr(2'd2, 8'hFD);
    ticks(0, 2);
    rd(2'd2, v); chk("R2 up steps", v, 8'hFF);
    chk("R2 no wrap before top", wrap_o, 1'b0);
    ticks(0, 1);
    chk("R2 wrap pulse", wrap_o, 1'b1);
    rd(2'd2, v); chk("R2 wrap to zero", v, 8'h00);
    @(negedge clk);
    chk("R2 wrap one cycle", wrap_o, 1'b0);
    chk("R2 flag set", irq_o, 1'b1);
  endtask

  task automatic t_flag;
    logic [7:0] v;
    wr(2'd3, 8'h01);
    chk("R9 write one keeps flag", irq_o, 1'b1);
    wr(2'd3, 8'h00);
    chk("R9 clear", irq_o, 1'b0);
    rd(2'd3, v); chk("R9 status reads 0", v, 8'h00);
    wr(2'd2, 8'hFF);
    @(negedge clk);
    tick_i[0] = 1'b1; bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = 8'h00;
    @(negedge clk);
    tick_i[0] = 1'b0; bus_wr = 1'b0;
    chk("R9 set wins over clear", irq_o, 1'b1);
    rd(2'd3, v); chk("R9 status bit0", v, 8'h01);
    wr(2'd3, 8'h00);
  endtask

  task automatic t_interval_down;
    logic [7:0] v;
    wr(2'd0, 8'h20);
    wr(2'd2, 8'h01);
    ticks(0, 1);
    rd(2'd2, v); chk("R3 down step", v, 8'h00);
    ticks(0, 1);
    chk("R3 underflow pulse", wrap_o, 1'b1);
    rd(2'd2, v); chk("R3 wrap to FF", v, 8'hFF);
    wr(2'd3, 8'h00);
  endtask

  task automatic t_reload;
    logic [7:0] v;
    wr(2'd0, 8'h80);
    wr(2'd1, 8'hF0);
    rd(2'd2, v); chk("R5 reload write loads count", v, 8'hF0);
    ticks(0, 15);
    rd(2'd2, v); chk("R4 up to top", v, 8'hFF);
    chk("R4 no early wrap", wrap_o, 1'b0);
    ticks(0, 1);
    chk("R4 wrap after 16", wrap_o, 1'b1);
    rd(2'd2, v); chk("R4 reloaded up", v, 8'hF0);
    wr(2'd1, 8'hFF);
    ticks(0, 1);
    chk("R4 period 1 wrap", wrap_o, 1'b1);
    rd(2'd2, v); chk("R4 period 1 count", v, 8'hFF);
    wr(2'd1, 8'h00);
    ticks(0, 255);
    rd(2'd2, v); chk("R4 period 256 top", v, 8'hFF);
    ticks(0, 1);
    chk("R4 period 256 wrap", wrap_o, 1'b1);
    rd(2'd2, v); chk("R4 period 256 count", v, 8'h00);
    wr(2'd0, 8'hA0);
    wr(2'd1, 8'h03);
    ticks(0, 3);
    rd(2'd2, v); chk("R4 down to zero", v, 8'h00);
    ticks(0, 1);
    chk("R4 down wrap", wrap_o, 1'b1);
    rd(2'd2, v); chk("R4 reloaded down", v, 8'h03);
    wr(2'd3, 8'h00);
  endtask

  task automatic t_interval_reload_write;
    logic [7:0] v;
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h10);
    wr(2'd1, 8'h55);
    rd(2'd2, v); chk("R5 interval keeps count", v, 8'h10);
    rd(2'd1, v); chk("R5 reload stored", v, 8'h55);
  endtask

  task automatic t_select;
    logic [7:0] v;
    wr(2'd0, 8'h03);
    wr(2'd2, 8'h10);
    ticks(0, 1);
    ticks(5, 1);
    rd(2'd2, v); chk("R6 other ticks ignored", v, 8'h10);
    ticks(3, 1);
    rd(2'd2, v); chk("R6 selected tick", v, 8'h11);
    @(negedge clk); tick_i = '1;
    @(negedge clk); tick_i = '0;
    rd(2'd2, v); chk("R10 one step per clock", v, 8'h12);
    @(negedge clk);
    tick_i[3] = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h40;
    @(negedge clk);
    tick_i[3] = 1'b0; bus_wr = 1'b0;
    rd(2'd2, v); chk("R10 write beats step", v, 8'h40);
  endtask

  task automatic t_hw_dir;
    logic [7:0] v;
    wr(2'd0, 8'h60);
    wr(2'd2, 8'h10);
    dir_pin = 1'b0;
    ticks(0, 1);
    rd(2'd2, v); chk("R8 pin low counts up", v, 8'h11);
    dir_pin = 1'b1;
    ticks(0, 1);
    rd(2'd2, v); chk("R8 pin high counts down", v, 8'h10);
    dir_pin = 1'b0;
    wr(2'd0, 8'h20);
    ticks(0, 1);
    rd(2'd2, v); chk("R8 software down", v, 8'h0F);
    wr(2'd0, 8'hFF);
    rd(2'd0, v); chk("R11 control bit3 reads 0", v, 8'hF7);
  endtask

  task automatic t_external;
    logic [7:0] v;
    wr(2'd0, 8'h07);
    wr(2'd2, 8'h00);
    @(negedge clk); event_pin = 1'b1;
    @(negedge clk); rd(2'd2, v); chk("R7 no step after 1 edge", v, 8'h00);
    @(negedge clk); rd(2'd2, v); chk("R7 no step after 2 edges", v, 8'h00);
    @(negedge clk); rd(2'd2, v); chk("R7 step at 3rd edge", v, 8'h01);
    @(negedge clk); event_pin = 1'b0;
    repeat (5) @(negedge clk);
    rd(2'd2, v); chk("R7 falling ignored in rising mode", v, 8'h01);
    @(negedge clk); tick_i = '1;
    repeat (3) @(negedge clk);
    tick_i = '0;
    rd(2'd2, v); chk("R7 ticks ignored in event mode", v, 8'h01);
    wr(2'd0, 8'h17);
    @(negedge clk); event_pin = 1'b1;
    repeat (5) @(negedge clk);
    rd(2'd2, v); chk("R7 rising ignored in falling mode", v, 8'h01);
    @(negedge clk); event_pin = 1'b0;
    repeat (5) @(negedge clk);
    rd(2'd2, v); chk("R7 falling counted", v, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_interval_up();
    t_flag();
    t_interval_down();
    t_reload();
    t_interval_reload_write();
    t_select();
    t_hw_dir();
    t_external();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule